// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches two active-low external request pins and turns activity on them into request flags held in a small control register. Each source has its own trigger mode bit. With the mode bit clear the source is level sensitive, and every cycle in which its sensed pin is low sets the flag. With the mode bit set the source is edge sensitive, and only a high-to-low transition sets the flag. The sensed value of each pin is the pin level ANDed with the matching output latch bit. That value passes through a two-flop synchronizer before detection.

Software reaches the control register in two ways: a whole-register write, or a single-bit write through a small bit-address window. A separate enable register gates each flag into a pending output. A fixed selector reports the vector address of the highest-ranked pending source. The processor clears a flag either by writing 0 to it or by pulsing that source's acknowledge input when it vectors there. A sticky indicator records that the enable register has been written since reset.

Top module: `extint_unit`

## Requirements
- R1: After reset the control register reads 0, the enable register reads 0, no source is pending, `sel_valid` is 0, `sel_vector` is 0 and `en_wr_seen` is 0.
- R2: The value sensed for source i is `pin_lvl[i] & port_latch[i]`. A low latch bit makes the source see a low pin even while the pin itself is high.
- R3: In level mode (mode bit 0), a sensed low value that is applied before clock edge k sets the flag after edge k+2. The flag stays set while the pin is low, and it reads 0 after edge k+1.
- R4: In edge mode (mode bit 1), a flag is set only when the synchronized sample goes from 1 to 0. A pin held low does not set the flag again once the flag has been cleared.
- R5: The control register layout is fixed. Bit 0 is the mode of source 0, bit 1 is the flag of source 0, bit 2 is the mode of source 1, and bit 3 is the flag of source 1. A whole-register write loads all four bits, and `ctl_rd` shows the same layout.
- R6: A bit write to address 0x88+n, with n from 0 to 3, loads control bit n with `bit_val`. A bit write to any other address changes nothing. If a whole-register write happens in the same cycle, the whole-register write wins.
- R7: An acknowledge pulse on `ack[i]` clears flag i, unless the same cycle writes that flag. A detection event in the same cycle overrides both the acknowledge and a write of 0.
- R8: `pending[i]` equals flag i ANDed with enable bit i. The enable register is loaded whole by `en_we`, with bit i enabling source i.
- R9: When any source is pending, `sel_valid` is 1. `sel_vector` is then 0x0003 if source 0 is pending (rank 1), and otherwise 0x0013 (source 1, rank 3). When nothing is pending, `sel_valid` is 0 and `sel_vector` is 0.
- R10: `en_wr_seen` becomes 1 after the first enable-register write. Only reset returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 2 | Raw request pin levels, active low |
| port_latch | input | 2 | Output latch bits ANDed with the pins |
| ctl_we | input | 1 | Whole control-register write strobe |
| ctl_wd | input | 4 | Whole control-register write data |
| bit_we | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address for single-bit writes |
| bit_val | input | 1 | Value for a single-bit write |
| en_we | input | 1 | Enable-register write strobe |
| en_wd | input | 2 | Enable-register write data |
| ack | input | 2 | Per-source acknowledge pulses that clear flags |
| ctl_rd | output | 4 | Control register contents (modes and flags) |
| en_rd | output | 2 | Enable register contents |
| pending | output | 2 | Flag AND enable, per source |
| sel_valid | output | 1 | Some source is pending |
| sel_vector | output | 16 | Vector address of the winning pending source |
| en_wr_seen | output | 1 | Sticky record of an enable-register write |

## Verification
The bench measures the exact two-cycle synchronizer delay plus the flag register. A design with one stage too few or too many would set the flag one cycle early or one cycle late. In edge mode it holds a pin low after an acknowledge, which catches a design that re-arms on the level. It also acknowledges a level source while its pin is still low, which catches a design that lets the clear override detection. Writes just outside the bit window, and a latch bit of 0 under a high pin, expose address decoding that is too wide or a sensed value that ignores the latch. A random phase compares every output against a cycle model in the bench, including which vector is chosen when both sources are pending.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;
  localparam logic [15:0] VEC_BASE = 16'h0003;
  localparam logic [15:0] VEC_STEP = 16'h0010;

  // Vector address of source idx
  function automatic logic [15:0] vec_of(input int unsigned idx);
    return 16'(VEC_BASE + 16'(idx) * VEC_STEP);
  endfunction

  // Ranking index of source idx; lower wins
  function automatic int unsigned rank_of(input int unsigned idx);
    return 2 * idx + 1;
  endfunction

  // Is address a inside the bit window [base, base+w)
  function automatic logic in_bit_window(input logic [7:0] a,
                                         input logic [7:0] base,
                                         input int unsigned w);
    return (int'(a) >= int'(base)) && (int'(a) < int'(base) + int'(w));
  endfunction

  // Level or falling-edge detection for one source
  function automatic logic detect_one(input logic edge_mode,
                                      input logic prev_smp,
                                      input logic cur_smp);
    return edge_mode ? (prev_smp & ~cur_smp) : ~cur_smp;
  endfunction
endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
  parameter int unsigned NSRC   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] d,
  output logic [NSRC-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d[gi]};
      end
      assign q[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/extint_detect.sv
`timescale 1ns/1ps
module extint_detect #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] smp,
  input  logic [NSRC-1:0] edge_mode,
  output logic [NSRC-1:0] set_ev
);
  logic [NSRC-1:0] prev_smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_smp <= '1;
    else        prev_smp <= smp;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_det
      assign set_ev[gi] = extint_pkg::detect_one(edge_mode[gi], prev_smp[gi], smp[gi]);

      // Two edge events in a row are impossible: the first leaves the stored sample low
      assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode[gi] && set_ev[gi]) |=> !(edge_mode[gi] && set_ev[gi]))
        else $error("edge event repeated on source %0d", gi);
    end
  endgenerate
endmodule

// File: rtl/extint_regs.sv
`timescale 1ns/1ps
module extint_regs #(
  parameter int unsigned NSRC     = 2,
  parameter logic [7:0]  BIT_BASE = 8'h88,
  localparam int unsigned CTL_W   = 2 * NSRC,
  localparam int unsigned OFF_W   = $clog2(CTL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set_ev,
  input  logic [NSRC-1:0]  ack,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wd,
  input  logic             bit_we,
  input  logic [7:0]       bit_addr,
  input  logic             bit_val,
  input  logic             en_we,
  input  logic [NSRC-1:0]  en_wd,
  output logic [NSRC-1:0]  mode,
  output logic [NSRC-1:0]  flag,
  output logic [NSRC-1:0]  en,
  output logic             seen
);
  logic [CTL_W-1:0] wr_mask;
  logic [CTL_W-1:0] wr_val;
  logic [OFF_W-1:0] bit_off;
  logic             bit_hit;

  assign bit_off = OFF_W'(bit_addr - BIT_BASE);
  assign bit_hit = bit_we && extint_pkg::in_bit_window(bit_addr, BIT_BASE, CTL_W);

  // Whole-register write takes precedence over a bit write
  always_comb begin
    wr_mask = '0;
    wr_val  = '0;
    if (ctl_we) begin
      wr_mask = '1;
      wr_val  = ctl_wd;
    end else if (bit_hit) begin
      wr_mask[bit_off] = 1'b1;
      wr_val[bit_off]  = bit_val;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_bits
      localparam int unsigned MI = 2 * gi;
      localparam int unsigned FI = 2 * gi + 1;
      logic flag_keep;
      assign flag_keep = wr_mask[FI] ? wr_val[FI] : (flag[gi] & ~ack[gi]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode[gi] <= 1'b0;
          flag[gi] <= 1'b0;
        end else begin
          if (wr_mask[MI]) mode[gi] <= wr_val[MI];
          flag[gi] <= set_ev[gi] | flag_keep;
        end
      end

      assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[gi] |=> flag[gi])
        else $error("detection lost on source %0d", gi);

      assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[gi] && !set_ev[gi] && !wr_mask[FI]) |=> !flag[gi])
        else $error("acknowledge ignored on source %0d", gi);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      seen <= 1'b0;
    end else begin
      if (en_we) en <= en_wd;
      if (en_we) seen <= 1'b1;
    end
  end

  assert_seen_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> seen)
    else $error("enable-write record dropped");

  assert_seen_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !en_we) |=> !seen)
    else $error("enable-write record set without a write");
endmodule

// File: rtl/extint_unit.sv
`timescale 1ns/1ps
module extint_unit #(
  parameter int unsigned NSRC     = 2,
  parameter int unsigned STAGES   = 2,
  parameter logic [7:0]  BIT_BASE = 8'h88,
  localparam int unsigned CTL_W   = 2 * NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pin_lvl,
  input  logic [NSRC-1:0]  port_latch,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wd,
  input  logic             bit_we,
  input  logic [7:0]       bit_addr,
  input  logic             bit_val,
  input  logic             en_we,
  input  logic [NSRC-1:0]  en_wd,
  input  logic [NSRC-1:0]  ack,
  output logic [CTL_W-1:0] ctl_rd,
  output logic [NSRC-1:0]  en_rd,
  output logic [NSRC-1:0]  pending,
  output logic             sel_valid,
  output logic [15:0]      sel_vector,
  output logic             en_wr_seen
);
  logic [NSRC-1:0] sensed;
  logic [NSRC-1:0] smp;
  logic [NSRC-1:0] set_ev;
  logic [NSRC-1:0] mode;
  logic [NSRC-1:0] flag;

  assign sensed = pin_lvl & port_latch;

  extint_sync #(.NSRC(NSRC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sensed), .q(smp)
  );

  extint_detect #(.NSRC(NSRC)) u_det (
    .clk(clk), .rst_n(rst_n), .smp(smp), .edge_mode(mode), .set_ev(set_ev)
  );

  extint_regs #(.NSRC(NSRC), .BIT_BASE(BIT_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .ack(ack),
    .ctl_we(ctl_we), .ctl_wd(ctl_wd), .bit_we(bit_we), .bit_addr(bit_addr),
    .bit_val(bit_val), .en_we(en_we), .en_wd(en_wd),
    .mode(mode), .flag(flag), .en(en_rd), .seen(en_wr_seen)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_rd
      assign ctl_rd[2*gi]     = mode[gi];
      assign ctl_rd[2*gi + 1] = flag[gi];
    end
  endgenerate

  assign pending = flag & en_rd;

  // Pick the pending source with the lowest rank
  always_comb begin
    int unsigned best_rank;
    sel_valid  = 1'b0;
    sel_vector = '0;
    best_rank  = 0;
    for (int unsigned i = 0; i < NSRC; i++) begin
      if (pending[i] && (!sel_valid || extint_pkg::rank_of(i) < best_rank)) begin
        sel_valid  = 1'b1;
        sel_vector = extint_pkg::vec_of(i);
        best_rank  = extint_pkg::rank_of(i);
      end
    end
  end

  assert_pending_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~en_rd) == '0)
    else $error("pending without enable");

  assert_sel_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid == (|pending))
    else $error("selector valid mismatch");

  assert_sel_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending[0] |-> (sel_vector == extint_pkg::vec_of(0)))
    else $error("source 0 not preferred");
endmodule

// File: tb/sim_extint_unit.sv
`timescale 1ns/1ps
module sim_extint_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pin_lvl = 2'b11;
  logic [1:0]  port_latch = 2'b11;
  logic        ctl_we = 1'b0;
  logic [3:0]  ctl_wd = '0;
  logic        bit_we = 1'b0;
  logic [7:0]  bit_addr = '0;
  logic        bit_val = 1'b0;
  logic        en_we = 1'b0;
  logic [1:0]  en_wd = '0;
  logic [1:0]  ack = '0;
  logic [3:0]  ctl_rd;
  logic [1:0]  en_rd;
  logic [1:0]  pending;
  logic        sel_valid;
  logic [15:0] sel_vector;
  logic        en_wr_seen;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench model state
  bit [1:0] m_s1, m_s2, m_prev, m_en;
  bit [3:0] m_ctl;
  bit       m_seen;

  always #5 clk = ~clk;

  extint_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .port_latch(port_latch),
    .ctl_we(ctl_we), .ctl_wd(ctl_wd), .bit_we(bit_we), .bit_addr(bit_addr),
    .bit_val(bit_val), .en_we(en_we), .en_wd(en_wd), .ack(ack),
    .ctl_rd(ctl_rd), .en_rd(en_rd), .pending(pending), .sel_valid(sel_valid),
    .sel_vector(sel_vector), .en_wr_seen(en_wr_seen)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [1:0] exp_pend();
    return {m_ctl[3] & m_en[1], m_ctl[1] & m_en[0]};
  endfunction

  function automatic bit [15:0] exp_vec(input bit [1:0] p);
    if (p[0]) return 16'h0003;
    if (p[1]) return 16'h0013;
    return 16'h0000;
  endfunction

  task automatic model_reset();
    m_s1 = 2'b11; m_s2 = 2'b11; m_prev = 2'b11;
    m_ctl = '0; m_en = '0; m_seen = 0;
  endtask

  // One clock of the model, using the inputs held across the edge
  task automatic model_clk();
    bit [3:0] nxt;
    bit [1:0] ev;
    for (int i = 0; i < 2; i++) begin
      if (m_ctl[2*i]) ev[i] = m_prev[i] && !m_s2[i];
      else            ev[i] = !m_s2[i];
    end
    nxt = m_ctl;
    if (ack[0]) nxt[1] = 0;
    if (ack[1]) nxt[3] = 0;
    if (ctl_we) nxt = ctl_wd;
    else if (bit_we && bit_addr >= 8'h88 && bit_addr <= 8'h8B) nxt[bit_addr - 8'h88] = bit_val;
    nxt[1] = nxt[1] | ev[0];
    nxt[3] = nxt[3] | ev[1];
    m_ctl = nxt;
    m_prev = m_s2;
    m_s2 = m_s1;
    m_s1 = pin_lvl & port_latch;
    if (en_we) begin m_en = en_wd; m_seen = 1; end
  endtask

  task automatic cmp_all();
    bit [1:0] p;
    p = exp_pend();
    chk(ctl_rd == m_ctl, "R2 R3 R4 R5 R6 R7 ctl", 32'(ctl_rd), 32'(m_ctl));
    chk(en_rd == m_en, "R8 en", 32'(en_rd), 32'(m_en));
    chk(pending == p, "R8 pending", 32'(pending), 32'(p));
    chk(sel_valid == (|p), "R9 valid", 32'(sel_valid), 32'(|p));
    chk(sel_vector == exp_vec(p), "R9 vector", 32'(sel_vector), 32'(exp_vec(p)));
    chk(en_wr_seen == m_seen, "R10 seen", 32'(en_wr_seen), 32'(m_seen));
  endtask

  task automatic step();
    @(posedge clk);
    model_clk();
    @(negedge clk);
    ctl_we = 0; bit_we = 0; en_we = 0; ack = '0;
    cmp_all();
  endtask

  task automatic bitw(input logic [7:0] a, input logic v);
    bit_we = 1; bit_addr = a; bit_val = v;
    step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctl_rd == 4'h0, "R1 ctl", 32'(ctl_rd), 0);
    chk(en_rd == 2'b00 && pending == 2'b00, "R1 en/pending", 32'({en_rd, pending}), 0);
    chk(!sel_valid && sel_vector == 16'h0, "R1 sel", 32'({sel_valid, sel_vector}), 0);
    chk(!en_wr_seen, "R1 seen", 32'(en_wr_seen), 0);
    rst_n = 1;

    // R3 level-mode latency on source 0
    pin_lvl = 2'b10;
    step(); step();
    chk(ctl_rd[1] == 0, "R3 flag early", 32'(ctl_rd[1]), 0);
    step();
    chk(ctl_rd[1] == 1, "R3 flag set", 32'(ctl_rd[1]), 1);
    chk(pending == 2'b00, "R8 gated off", 32'(pending), 0);

    en_we = 1; en_wd = 2'b01; step();
    chk(pending == 2'b01, "R8 enabled", 32'(pending), 1);
    chk(sel_vector == 16'h0003 && sel_valid, "R9 src0 vector", 32'(sel_vector), 32'h3);
    chk(en_wr_seen, "R10 seen set", 32'(en_wr_seen), 1);

    // R7 detection beats acknowledge while level pin still low
    ack = 2'b01; step();
    chk(ctl_rd[1] == 1, "R7 set wins", 32'(ctl_rd[1]), 1);

    pin_lvl = 2'b11; step(); step(); step();
    ack = 2'b01; step();
    chk(ctl_rd[1] == 0, "R7 ack clears", 32'(ctl_rd[1]), 0);
    ctl_we = 1; ctl_wd = 4'h0; step();
    chk(ctl_rd == 4'h0, "R5 whole write", 32'(ctl_rd), 0);

    // R4 edge mode through bit write 0x88
    bitw(8'h88, 1);
    chk(ctl_rd == 4'b0001, "R6 bit write", 32'(ctl_rd), 1);
    pin_lvl = 2'b10; step(); step(); step();
    chk(ctl_rd[1] == 1, "R4 edge sets", 32'(ctl_rd[1]), 1);
    ack = 2'b01; step();
    repeat (5) step();
    chk(ctl_rd[1] == 0, "R4 steady low", 32'(ctl_rd[1]), 0);

    // R6 out-of-window address ignored
    bitw(8'h8C, 1);
    chk(ctl_rd == 4'b0001, "R6 outside window", 32'(ctl_rd), 1);
    bitw(8'h87, 1);
    chk(ctl_rd == 4'b0001, "R6 below window", 32'(ctl_rd), 1);

    // R2 latch low masks a high pin
    pin_lvl = 2'b11; port_latch = 2'b01;
    step(); step(); step();
    chk(ctl_rd[3] == 1, "R2 latch masks", 32'(ctl_rd[3]), 1);
    en_we = 1; en_wd = 2'b11; step();
    chk(sel_vector == 16'h0013, "R9 src1 vector", 32'(sel_vector), 32'h13);
    bitw(8'h89, 1);
    chk(pending == 2'b11 && sel_vector == 16'h0003, "R9 both pending", 32'(sel_vector), 32'h3);
    ctl_we = 1; ctl_wd = 4'b0101; bit_we = 1; bit_addr = 8'h8A; bit_val = 0; step();
    chk(ctl_rd[2] == 1, "R6 whole write wins", 32'(ctl_rd[2]), 1);

    // Random phase against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) pin_lvl = 2'($urandom);
      if ($urandom_range(31) == 0) port_latch = 2'($urandom) | 2'($urandom);
      if ($urandom_range(15) == 0) begin ctl_we = 1; ctl_wd = 4'($urandom); end
      if ($urandom_range(7) == 0) begin
        bit_we = 1; bit_addr = 8'h86 + 8'($urandom_range(7)); bit_val = 1'($urandom);
      end
      if ($urandom_range(31) == 0) begin en_we = 1; en_wd = 2'($urandom); end
      if ($urandom_range(5) == 0) ack = 2'($urandom);
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule